// File: doc/BRIEF.md
# PLL Divider Search Engine

This block looks for the divider settings of a phase-locked clock synthesizer. It is given a target pixel clock and a reference frequency, both in kHz. It then walks a range of reference dividers M and a table of eight post-divider values P. For each pair it takes the feedback divider N that brings R·N/(M·P) nearest the target, and it keeps the setting with the smallest error. When the search finishes it reports N, M, the index of the chosen post-divider table entry, the frequency that setting produces, and a fail flag.

Software or a mode-setting sequencer loads the configuration and pulses `start`. It then waits for the one-cycle `done` pulse and reads the results. A single multi-cycle restoring divider does every division in sequence, so the engine is small and slow: each candidate costs two full divisions. An optional VCO ceiling removes post-dividers that would push the undivided oscillator above a limit. An integrated-PLL option doubles the reference before the search begins.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `n_out`, `m_out`, `d_out` and `synth_khz` are all zero.
- R2: A `start` pulse seen while `busy` is low makes `busy` high on the next cycle. Completion is signalled by `done` high for exactly one cycle, with `busy` low in that cycle. A `start` pulse while `busy` is high is ignored, and the search already running keeps its latched target.
- R3: The achieved frequency of a candidate is round(Reff·N/(M·P)). Rounding is half up, computed as floor((x + floor(d/2))/d).
- R4: M runs from `m_min` to `m_max` inclusive in the outer loop. Table index 0..7 runs in the inner loop. The reported setting is the one with the smallest |achieved − target|.
- R5: A later candidate with the same error replaces the current best only if its N is strictly larger. Otherwise the earliest one in search order is kept.
- R6: For each candidate, N is round(target·M·P/Reff) with the rounding of R3, then clamped to [`n_min`, `n_max`].
- R7: With `pd_set`=0 the post-divider values for index 0..7 are 1,2,4,8,16,32,64,128. With `pd_set`=1 they are 1,2,4,8,3,0,6,12. An entry of 0 is never evaluated. `d_out` reports the table index.
- R8: When `vco_limit_khz` is nonzero, an entry P is skipped if `vco_limit_khz` < target·P. An entry with `vco_limit_khz` = target·P is still evaluated.
- R9: With `ref_double`=1 the reference used is 2·`ref_khz`. With `ref_double`=0 it is `ref_khz`.
- R10: `fail` is raised with `done` if |achieved − target| > TOL (default 2000 kHz). It is also raised if no entry was evaluated, and in that case N, M, D and `synth_khz` are reported as 0.
- R11: The result outputs hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only while idle) |
| target_khz | input | FW | Requested frequency in kHz, latched at start |
| ref_khz | input | FW | Reference frequency in kHz, latched at start |
| ref_double | input | 1 | Use twice the reference (integrated PLL) |
| n_min | input | NW | Lowest allowed feedback divider |
| n_max | input | NW | Highest allowed feedback divider |
| m_min | input | MW | First reference divider tried (at least 1) |
| m_max | input | MW | Last reference divider tried |
| pd_set | input | 1 | Post-divider table select |
| vco_limit_khz | input | FW | VCO ceiling in kHz, 0 disables |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| n_out | output | NW | Chosen feedback divider |
| m_out | output | MW | Chosen reference divider |
| d_out | output | 3 | Chosen post-divider table index |
| synth_khz | output | FW | Achieved frequency, saturated to FW bits |
| fail | output | 1 | No setting within tolerance |

## Verification
The bench builds the engine with its defaults: FW=20, NW=9, MW=9, PDW=8 and TOL=2000. This makes the full 1..128 post-divider range and display-class targets near 14.318 MHz references reachable. The same widths let a 1000 kHz reference produce exact ties, exact half-way roundings and errors of exactly 2000 and 2001 kHz. A stimulus table of realistic targets is compared against a behavioural search model. Directed cases then pin the tie rule, table variant, VCO ceiling boundary, reference doubling, clamping, rounding and the ignored start.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    localparam int PD_IDXW = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WAIT_N,
        ST_WAIT_F,
        ST_STEP,
        ST_FINISH
    } srch_state_e;
endpackage

// File: rtl/pll_pd_table.sv
module pll_pd_table
    import pll_search_pkg::*;
#(
    parameter int PDW = 8
) (
    input  logic               set_sel,
    input  logic [PD_IDXW-1:0] idx,
    output logic [PDW-1:0]     value
);
    always_comb begin
        if (!set_sel) begin
            value = PDW'(1) << idx;
        end else begin
            case (idx)
                3'd0:    value = PDW'(1);
                3'd1:    value = PDW'(2);
                3'd2:    value = PDW'(4);
                3'd3:    value = PDW'(8);
                3'd4:    value = PDW'(3);
                3'd5:    value = PDW'(0);
                3'd6:    value = PDW'(6);
                default: value = PDW'(12);
            endcase
        end
    end
endmodule

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
    parameter int NUMW = 38,
    parameter int DENW = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NUMW-1:0] num,
    input  logic [DENW-1:0] den,
    output logic            done,
    output logic [NUMW-1:0] quo
);
    localparam int CW = $clog2(NUMW + 1);

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CW-1:0]   cnt;
        logic [NUMW-1:0] sh;
        logic [DENW-1:0] rem;
        logic [DENW-1:0] den;
    } div_t;

    div_t r_q, r_d;
    logic [DENW:0] trial;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem, r_q.sh[NUMW-1]};
        if (go) begin
            r_d.busy = 1'b1;
            r_d.cnt  = CW'(NUMW);
            r_d.sh   = num;
            r_d.rem  = '0;
            r_d.den  = den;
        end else if (r_q.busy) begin
            if (trial >= {1'b0, r_q.den}) begin
                r_d.rem = DENW'(trial - {1'b0, r_q.den});
                r_d.sh  = {r_q.sh[NUMW-2:0], 1'b1};
            end else begin
                r_d.rem = trial[DENW-1:0];
                r_d.sh  = {r_q.sh[NUMW-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done = r_q.done;
    assign quo  = r_q.sh;

    // R3: a finished division leaves a remainder below the divisor
    p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && r_q.den != '0) |-> (r_q.rem < r_q.den));

    // R3: the divider result strobe lasts a single cycle
    p_div_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FW  = 20,
    parameter int NW  = 9,
    parameter int MW  = 9,
    parameter int PDW = 8,
    parameter int TOL = 2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FW-1:0]      target_khz,
    input  logic [FW-1:0]      ref_khz,
    input  logic               ref_double,
    input  logic [NW-1:0]      n_min,
    input  logic [NW-1:0]      n_max,
    input  logic [MW-1:0]      m_min,
    input  logic [MW-1:0]      m_max,
    input  logic               pd_set,
    input  logic [FW-1:0]      vco_limit_khz,
    output logic               busy,
    output logic               done,
    output logic [NW-1:0]      n_out,
    output logic [MW-1:0]      m_out,
    output logic [PD_IDXW-1:0] d_out,
    output logic [FW-1:0]      synth_khz,
    output logic               fail
);
    localparam int RW   = FW + 1;
    localparam int MLW  = MW + PDW;
    localparam int TPW  = FW + PDW;
    localparam int NUMW = FW + MW + PDW + 1;
    localparam int DENW = (RW > MLW) ? RW : MLW;
    localparam logic [PD_IDXW-1:0] LAST_IDX = '1;

    typedef struct packed {
        srch_state_e        st;
        logic [MW-1:0]      m;
        logic [PD_IDXW-1:0] d;
        logic [FW-1:0]      tgt;
        logic [RW-1:0]      rf;
        logic [MLW-1:0]     mult;
        logic [NW-1:0]      cn;
        logic [NW-1:0]      bn;
        logic [MW-1:0]      bm;
        logic [PD_IDXW-1:0] bd;
        logic [NUMW-1:0]    bf;
        logic [NUMW-1:0]    be;
        logic               any;
        logic               done;
        logic               fail;
    } srch_t;

    srch_t r_q, r_d;

    logic [PDW-1:0]  pd_val;
    logic            div_go;
    logic [NUMW-1:0] div_num;
    logic [DENW-1:0] div_den;
    logic            div_done;
    logic [NUMW-1:0] div_quo;
    logic [TPW-1:0]  tgt_x_pd;
    logic            pd_skip;
    logic [NW-1:0]   n_clamped;
    logic [NUMW-1:0] err;
    logic            better;

    pll_pd_table #(.PDW(PDW)) u_table (
        .set_sel (pd_set),
        .idx     (r_q.d),
        .value   (pd_val)
    );

    pll_rdiv #(.NUMW(NUMW), .DENW(DENW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        tgt_x_pd = TPW'(r_q.tgt) * TPW'(pd_val);
        pd_skip  = (pd_val == '0) ||
                   ((vco_limit_khz != '0) && (TPW'(vco_limit_khz) < tgt_x_pd));

        if (div_quo < NUMW'(n_min))      n_clamped = n_min;
        else if (div_quo > NUMW'(n_max)) n_clamped = n_max;
        else                             n_clamped = div_quo[NW-1:0];

        err    = (div_quo >= NUMW'(r_q.tgt)) ? (div_quo - NUMW'(r_q.tgt))
                                              : (NUMW'(r_q.tgt) - div_quo);
        better = (err < r_q.be) || ((err == r_q.be) && (r_q.bn < r_q.cn));
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        div_num  = '0;
        div_den  = '0;

        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = (m_min > m_max) ? ST_FINISH : ST_EVAL;
                    r_d.m    = m_min;
                    r_d.d    = '0;
                    r_d.tgt  = target_khz;
                    r_d.rf   = ref_double ? (RW'(ref_khz) << 1) : RW'(ref_khz);
                    r_d.bn   = '0;
                    r_d.bm   = '0;
                    r_d.bd   = '0;
                    r_d.bf   = '0;
                    r_d.be   = '1;
                    r_d.any  = 1'b0;
                    r_d.fail = 1'b0;
                end
            end
            ST_EVAL: begin
                if (pd_skip) begin
                    r_d.st = ST_STEP;
                end else begin
                    r_d.mult = MLW'(r_q.m) * MLW'(pd_val);
                    div_go   = 1'b1;
                    div_num  = NUMW'(r_q.tgt) * NUMW'(r_q.m) * NUMW'(pd_val)
                             + NUMW'(r_q.rf >> 1);
                    div_den  = DENW'(r_q.rf);
                    r_d.st   = ST_WAIT_N;
                end
            end
            ST_WAIT_N: begin
                if (div_done) begin
                    r_d.cn  = n_clamped;
                    div_go  = 1'b1;
                    div_num = NUMW'(n_clamped) * NUMW'(r_q.rf)
                            + NUMW'(r_q.mult >> 1);
                    div_den = DENW'(r_q.mult);
                    r_d.st  = ST_WAIT_F;
                end
            end
            ST_WAIT_F: begin
                if (div_done) begin
                    if (better) begin
                        r_d.bn = r_q.cn;
                        r_d.bm = r_q.m;
                        r_d.bd = r_q.d;
                        r_d.bf = div_quo;
                        r_d.be = err;
                    end
                    r_d.any = 1'b1;
                    r_d.st  = ST_STEP;
                end
            end
            ST_STEP: begin
                if (r_q.d == LAST_IDX) begin
                    r_d.d = '0;
                    if (r_q.m >= m_max) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.m  = r_q.m + MW'(1);
                        r_d.st = ST_EVAL;
                    end
                end else begin
                    r_d.d  = r_q.d + PD_IDXW'(1);
                    r_d.st = ST_EVAL;
                end
            end
            ST_FINISH: begin
                r_d.done = 1'b1;
                r_d.fail = !r_q.any || (r_q.be > NUMW'(TOL));
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign fail      = r_q.fail;
    assign n_out     = r_q.bn;
    assign m_out     = r_q.bm;
    assign d_out     = r_q.bd;
    assign synth_khz = (|r_q.bf[NUMW-1:FW]) ? '1 : r_q.bf[FW-1:0];

    // R2: an accepted start makes the engine busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: completion strobe is one cycle wide and coincides with idle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: the best error never grows during a search
    p_err_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (r_q.be <= $past(r_q.be)));

    // R6: a reported divider lies inside the configured range
    p_n_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.any) |-> (n_out >= n_min && n_out <= n_max));

    // R7: a zero table entry is never sent to the divider
    p_zero_skipped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_EVAL && pd_val == '0) |-> !div_go);

    // R10: a search with nothing evaluated fails with zeroed results
    p_none_fails_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.any) |-> (fail && n_out == '0 && synth_khz == '0));

    // R10: a passing result is within tolerance of the latched target
    p_pass_within_tol_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> ((NUMW'(synth_khz) + NUMW'(TOL) >= NUMW'(r_q.tgt)) &&
                             (NUMW'(synth_khz) <= NUMW'(r_q.tgt) + NUMW'(TOL))));

    // R11: results hold while idle with no start
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !done) |=> ($stable(n_out) && $stable(m_out) &&
                                        $stable(d_out) && $stable(fail)));
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
    localparam int FW  = 20;
    localparam int NW  = 9;
    localparam int MW  = 9;
    localparam int PDW = 8;
    localparam int TOL = 2000;
    localparam int WAIT_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [FW-1:0] target_khz = '0;
    logic [FW-1:0] ref_khz = '0;
    logic          ref_double = 1'b0;
    logic [NW-1:0] n_min = '0;
    logic [NW-1:0] n_max = '0;
    logic [MW-1:0] m_min = '0;
    logic [MW-1:0] m_max = '0;
    logic          pd_set = 1'b0;
    logic [FW-1:0] vco_limit_khz = '0;
    logic          busy, done, fail;
    logic [NW-1:0] n_out;
    logic [MW-1:0] m_out;
    logic [2:0]    d_out;
    logic [FW-1:0] synth_khz;

    int errors = 0;
    int checks = 0;
    longint got_n, got_m, got_d, got_f, got_fail;

    always #2 clk = ~clk;

    pll_div_search #(.FW(FW), .NW(NW), .MW(MW), .PDW(PDW), .TOL(TOL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
        .ref_khz(ref_khz), .ref_double(ref_double), .n_min(n_min), .n_max(n_max),
        .m_min(m_min), .m_max(m_max), .pd_set(pd_set), .vco_limit_khz(vco_limit_khz),
        .busy(busy), .done(done), .n_out(n_out), .m_out(m_out), .d_out(d_out),
        .synth_khz(synth_khz), .fail(fail)
    );

    typedef struct packed {
        int tgt; int rf; int dbl; int nmin; int nmax;
        int mmin; int mmax; int sel; int lim; int efail;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{25175,  14318, 0, 2, 255, 1,  8, 0, 0,      0},
        '{65000,  14318, 1, 2, 255, 2, 10, 1, 0,      0},
        '{40000,  14318, 0, 2, 255, 1, 12, 1, 100000, 0},
        '{100000, 14318, 0, 2, 20,  1,  2, 0, 0,      0},
        '{500000, 14318, 0, 2, 20,  1,  2, 0, 0,      1},
        '{108000, 14318, 1, 2, 255, 1,  6, 1, 400000, 0},
        '{31500,  14318, 0, 2, 255, 1,  4, 0, 0,      0}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint pd_of(input int sel, input int idx);
        int t1 [8] = '{1, 2, 4, 8, 3, 0, 6, 12};
        if (sel == 0) return longint'(1) << idx;
        return t1[idx];
    endfunction

    task automatic model(input vec_t v, output longint en, output longint em,
                         output longint ed, output longint ef, output longint efl);
        longint r, be, mult, n, f, e, p;
        bit any;
        r = (v.dbl != 0) ? 2 * v.rf : v.rf;
        be = 64'h7fff_ffff_ffff; en = 0; em = 0; ed = 0; ef = 0; any = 0;
        for (int m = v.mmin; m <= v.mmax; m++) begin
            for (int d = 0; d < 8; d++) begin
                p = pd_of(v.sel, d);
                if (p == 0) continue;
                if (v.lim != 0 && longint'(v.lim) < longint'(v.tgt) * p) continue;
                mult = m * p;
                n = (longint'(v.tgt) * mult + r / 2) / r;
                if (n < v.nmin) n = v.nmin;
                else if (n > v.nmax) n = v.nmax;
                f = (n * r + mult / 2) / mult;
                e = (f >= v.tgt) ? f - v.tgt : v.tgt - f;
                if (e < be || (e == be && en < n)) begin
                    be = e; en = n; em = m; ed = d; ef = f;
                end
                any = 1;
            end
        end
        efl = (!any || be > TOL) ? 1 : 0;
        if (ef > (longint'(1) << FW) - 1) ef = (longint'(1) << FW) - 1;
    endtask

    task automatic apply(input vec_t v);
        target_khz    = FW'(v.tgt);
        ref_khz       = FW'(v.rf);
        ref_double    = (v.dbl != 0);
        n_min         = NW'(v.nmin);
        n_max         = NW'(v.nmax);
        m_min         = MW'(v.mmin);
        m_max         = MW'(v.mmax);
        pd_set        = (v.sel != 0);
        vco_limit_khz = FW'(v.lim);
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < WAIT_LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL R2: done never seen, actual 0 expected 1");
        end
        got_n = n_out; got_m = m_out; got_d = d_out;
        got_f = synth_khz; got_fail = fail;
    endtask

    task automatic run(input vec_t v);
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        wait_done();
    endtask

    task automatic run_expect(input string tag, input vec_t v, input longint en,
                              input longint em, input longint ed, input longint ef,
                              input longint efl);
        run(v);
        chk({tag, " n"}, got_n, en);
        chk({tag, " m"}, got_m, em);
        chk({tag, " d"}, got_d, ed);
        chk({tag, " synth"}, got_f, ef);
        chk({tag, " fail"}, got_fail, efl);
    endtask

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL R2: watchdog expired, actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint en, em, ed, ef, efl;
        vec_t v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 fail", fail, 0);
        chk("R1 n", n_out, 0);
        chk("R1 m", m_out, 0);
        chk("R1 d", d_out, 0);
        chk("R1 synth", synth_khz, 0);

        // R4: table of realistic targets against the behavioural search
        for (int i = 0; i < NVEC; i++) begin
            model(VECS[i], en, em, ed, ef, efl);
            run(VECS[i]);
            chk("R4 n", got_n, en);
            chk("R4 m", got_m, em);
            chk("R4 d", got_d, ed);
            chk("R4 synth", got_f, ef);
            chk("R10 fail model", got_fail, efl);
            chk("R10 fail table", got_fail, VECS[i].efail);
        end

        // R5: exact ties across the table, larger N wins, equal N keeps first
        v = '{1000, 1000, 0, 1, 100, 1, 2, 0, 0, 0};
        run_expect("R5 tie", v, 64, 1, 6, 1000, 0);
        @(negedge clk);
        chk("R2 done one cycle", done, 0);
        // R11: results held while idle
        repeat (5) @(negedge clk);
        chk("R11 hold n", n_out, 64);
        chk("R11 hold d", d_out, 6);

        // R9: reference doubling
        v = '{1000, 500, 1, 1, 100, 1, 2, 0, 0, 0};
        run_expect("R9 doubled", v, 64, 1, 6, 1000, 0);
        v = '{1000, 500, 0, 1, 100, 1, 2, 0, 0, 0};
        run_expect("R9 single", v, 64, 1, 5, 1000, 0);

        // R7: second table, index 7 holds 12
        v = '{1000, 1000, 0, 1, 255, 1, 1, 1, 0, 0};
        run_expect("R7 set1", v, 12, 1, 7, 1000, 0);

        // R8: VCO ceiling boundary
        v = '{1000, 1000, 0, 1, 255, 1, 1, 0, 8000, 0};
        run_expect("R8 limit equal", v, 8, 1, 3, 1000, 0);
        v = '{1000, 1000, 0, 1, 255, 1, 1, 0, 7999, 0};
        run_expect("R8 limit below", v, 4, 1, 2, 1000, 0);

        // R6: half-way N rounds up
        v = '{1500, 1000, 0, 1, 255, 1, 1, 0, 1500, 0};
        run_expect("R6 round", v, 2, 1, 0, 2000, 0);
        // R3: achieved frequency 1001/2 rounds up to 501
        v = '{1001, 1001, 0, 1, 1, 2, 2, 0, 1001, 0};
        run_expect("R3 half up", v, 1, 2, 0, 501, 0);
        // R6: clamp to upper then lower bound
        v = '{1000, 1000, 0, 1, 1, 3, 3, 0, 1000, 0};
        run_expect("R6 clamp max", v, 1, 3, 0, 333, 0);
        v = '{1000, 1000, 0, 5, 255, 1, 1, 0, 1000, 0};
        run_expect("R6 clamp min", v, 5, 1, 0, 5000, 1);

        // R10: tolerance boundary and empty search
        v = '{3000, 1000, 0, 1, 1, 1, 1, 0, 3000, 0};
        run_expect("R10 err 2000", v, 1, 1, 0, 1000, 0);
        v = '{3001, 1000, 0, 1, 1, 1, 1, 0, 3001, 0};
        run_expect("R10 err 2001", v, 1, 1, 0, 1000, 1);
        v = '{25175, 14318, 0, 2, 255, 1, 4, 0, 1000, 0};
        run_expect("R10 none", v, 0, 0, 0, 0, 1);

        // R2: start while busy is ignored, latched target kept
        v = '{1000, 1000, 0, 1, 100, 1, 2, 0, 0, 0};
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        target_khz = FW'(5000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy during run", busy, 1);
        wait_done();
        chk("R2 ignored start n", got_n, 64);
        chk("R2 ignored start d", got_d, 6);
        chk("R2 ignored start synth", got_f, 1000);
        @(negedge clk);
        chk("R2 idle after run", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule